// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of address translations. A lookup presents a virtual page number. Every entry compares its stored page number against it at the same time. When address-space tagging is on, an entry must also carry the identifier of the running process. A matching entry returns its frame number and read-only flag in the same cycle. When nothing matches, the block raises a miss. An external table walker then supplies the translation as a fill, and the block installs it for later lookups.

Fills go to a free entry first, in lowest-index order. If the table is full, a round-robin pointer picks the entry to replace and skips entries marked as wired. A fill whose page number and identifier already match a valid entry rewrites that entry instead of adding a second copy. If every entry is wired, the fill is dropped and a one-cycle error pulse follows.

A flush invalidates entries in one cycle and never touches wired entries. With tagging on, it removes only the running process's entries. With tagging off, which is the context-switch case, it removes every unwired entry.

Top module: `asid_tlb`

## Requirements
- R1: A lookup (`lk_valid`=1) whose page number matches a valid entry asserts `hit` in the same cycle, with that entry's `hit_pfn` and `hit_ro`. If several entries match, the lowest index wins. With `lk_valid`=0, `hit` and `miss` are both 0.
- R2: After reset no entry is valid. A lookup that matches no valid entry asserts `miss` and leaves `hit` low.
- R3: With `asid_en`=1, an entry whose stored identifier differs from `cur_asid` does not hit.
- R4: With `asid_en`=0, the stored identifier is ignored on lookup.
- R5: A fill captured on a clock edge is visible to lookups from the following cycle, unless it is dropped.
- R6: A fill whose page number and identifier both equal those of a valid entry rewrites that entry's frame and read-only flag. No other entry changes.
- R7: A fill goes to the lowest-index invalid entry and leaves the replacement pointer alone. With no invalid entry, it replaces the entry at the pointer. The pointer starts at entry 0 after reset and then moves to the entry after the one replaced.
- R8: A fill with `fill_wired`=1 marks its entry wired until reset. A wired entry is never chosen for replacement; the pointer passes over it.
- R9: `flush` with `asid_en`=1 invalidates every unwired entry whose identifier equals `cur_asid`. Other entries stay valid.
- R10: `flush` with `asid_en`=0 invalidates every unwired entry. Wired entries stay valid.
- R11: When every entry is valid and wired, a new fill is dropped and the table does not change. `fill_drop` is 1 during the cycle after the dropped fill's edge and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asid_en | input | 1 | Address-space tagging enable |
| cur_asid | input | 8 | Identifier of the running process |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| hit | output | 1 | Lookup matched |
| miss | output | 1 | Lookup found no match |
| hit_pfn | output | 20 | Frame number of the matching entry |
| hit_ro | output | 1 | Read-only flag of the matching entry |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Identifier to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_ro | input | 1 | Read-only flag to install |
| fill_wired | input | 1 | Mark the installed entry as wired |
| flush | input | 1 | Invalidate unwired entries per R9 and R10 |
| fill_drop | output | 1 | Pulse after a fill that found no replaceable entry |

## Verification
Lookup results are combinational. The bench sets a lookup just after a falling edge and reads `hit`, `miss` and the frame 1 ns later, in the same cycle. Fills and flushes take effect on the next rising edge, so their effect is checked by lookups from the following falling edge onward. `fill_drop` comes from one register and is due at the first falling edge after the capturing edge; the bench samples it there and again one cycle later to see it fall. The replacement order is checked entry by entry: after each eviction, a sweep of all sixteen page numbers shows which single entry was lost.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asid_en,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic              miss,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              hit_ro,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_ro,
  input  logic              fill_wired,
  input  logic              flush,
  output logic              fill_drop
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, wired_q, ro_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [IW-1:0]      rr_q;

  logic [ENTRIES-1:0] lk_match, dup_match, kill;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = valid_q[i] && vpn_q[i] == lk_vpn &&
                          (!asid_en || asid_q[i] == cur_asid);
    assign dup_match[i] = valid_q[i] && vpn_q[i] == fill_vpn && asid_q[i] == fill_asid;
    assign kill[i]      = flush && !wired_q[i] && (!asid_en || asid_q[i] == cur_asid);
  end

  assign hit  = lk_valid && (|lk_match);
  assign miss = lk_valid && !(|lk_match);

  always_comb begin
    hit_pfn = '0;
    hit_ro  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        hit_pfn = pfn_q[i];
        hit_ro  = ro_q[i];
      end
    end
  end

  logic          dup_any, free_any, rep_ok, drop, do_fill, evict;
  logic [IW-1:0] dup_idx, free_idx, rep_idx, tgt;

  always_comb begin
    dup_any  = 1'b0; dup_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    rep_ok   = 1'b0; rep_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dup_match[i]) begin dup_any = 1'b1;  dup_idx  = IW'(i); end
      if (!valid_q[i])  begin free_any = 1'b1; free_idx = IW'(i); end
    end
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (!wired_q[(int'(rr_q) + k) % ENTRIES]) begin
        rep_ok  = 1'b1;
        rep_idx = IW'((int'(rr_q) + k) % ENTRIES);
      end
    end
  end

  assign drop    = !dup_any && !free_any && !rep_ok;
  assign do_fill = fill_valid && !drop;
  assign evict   = do_fill && !dup_any && !free_any;
  assign tgt     = dup_any ? dup_idx : (free_any ? free_idx : rep_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      wired_q   <= '0;
      rr_q      <= '0;
      fill_drop <= 1'b0;
    end else begin
      fill_drop <= fill_valid && drop;
      if (do_fill) begin
        valid_q      <= (valid_q & ~kill) | (ENTRIES'(1) << tgt);
        wired_q[tgt] <= wired_q[tgt] | fill_wired;
      end else begin
        valid_q <= valid_q & ~kill;
      end
      if (evict)
        rr_q <= (int'(rep_idx) == ENTRIES - 1) ? '0 : rep_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      asid_q[tgt] <= fill_asid;
      vpn_q[tgt]  <= fill_vpn;
      pfn_q[tgt]  <= fill_pfn;
      ro_q[tgt]   <= fill_ro;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               asid_en,
  input logic [ASID_W-1:0]  cur_asid,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               hit,
  input logic               miss,
  input logic               fill_valid,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [ASID_W-1:0]  fill_asid,
  input logic               flush,
  input logic               fill_drop,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] wired_q
);
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (hit != miss)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!hit && !miss)); // R1

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && !flush && rst_n) && lk_valid && lk_vpn == $past(fill_vpn) &&
     (!asid_en || cur_asid == $past(fill_asid))) |-> (hit || fill_drop)); // R5

  AST_WIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(wired_q) & ~wired_q) == '0)); // R8

  AST_WIRED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((wired_q & ~valid_q) == '0)); // R8

  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush && !fill_valid && !asid_en && rst_n) |-> ((valid_q & ~wired_q) == '0)); // R10

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_drop |-> ($past(fill_valid) && $past(&wired_q))); // R11
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .asid_en(asid_en), .cur_asid(cur_asid),
  .lk_valid(lk_valid), .lk_vpn(lk_vpn), .hit(hit), .miss(miss),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
  .flush(flush), .fill_drop(fill_drop), .valid_q(valid_q), .wired_q(wired_q));

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic asid_en = 1'b1, lk_valid = 1'b0, fill_valid = 1'b0, fill_ro = 1'b0;
  logic fill_wired = 1'b0, flush = 1'b0;
  logic [7:0]  cur_asid = '0, fill_asid = '0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0;
  logic hit, miss, hit_ro, fill_drop;
  logic [19:0] hit_pfn;
  int n_chk = 0, n_fail = 0;
  logic last_drop;

  always #10 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .asid_en(asid_en), .cur_asid(cur_asid),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .hit(hit), .miss(miss),
    .hit_pfn(hit_pfn), .hit_ro(hit_ro), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .fill_ro(fill_ro), .fill_wired(fill_wired), .flush(flush),
    .fill_drop(fill_drop));

  function automatic logic [19:0] pf(int i);
    return 20'(i * 3 + 7);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] v, logic [7:0] a, logic [19:0] p, logic ro, logic w);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    fill_ro = ro; fill_wired = w;
    @(negedge clk);
    fill_valid = 1'b0; fill_wired = 1'b0;
    #1 last_drop = fill_drop;
  endtask

  task automatic do_flush(logic en, logic [7:0] a);
    @(negedge clk);
    asid_en = en; cur_asid = a; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic look(string tag, logic [19:0] v, logic en, logic [7:0] a,
                      logic eh, logic [19:0] ep, logic er);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; asid_en = en; cur_asid = a;
    #1;
    check({tag, " hit"}, 32'(hit), 32'(eh));
    check({tag, " miss"}, 32'(miss), 32'(!eh));
    if (eh) begin
      check({tag, " pfn"}, 32'(hit_pfn), 32'(ep));
      check({tag, " ro"}, 32'(hit_ro), 32'(er));
    end
    lk_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle hit", 32'(hit), 0);
    check("R1 idle miss", 32'(miss), 0);
    check("R11 reset drop", 32'(fill_drop), 0);
    for (int i = 0; i < 16; i++) look("R2 reset", 20'h100 + 20'(i), 1'b1, 8'd1, 1'b0, '0, 1'b0);

    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 8'd1, pf(i), 1'(i), 1'b0);
    check("R11 normal fill drop", 32'(last_drop), 0);
    for (int i = 0; i < 16; i++) look("R1/R5 sweep", 20'h100 + 20'(i), 1'b1, 8'd1, 1'b1, pf(i), 1'(i));
    look("R2 absent", 20'h0FF, 1'b1, 8'd1, 1'b0, '0, 1'b0);
    for (int i = 0; i < 16; i++) look("R3 other asid", 20'h100 + 20'(i), 1'b1, 8'd2, 1'b0, '0, 1'b0);
    for (int i = 0; i < 16; i++) look("R4 untagged", 20'h100 + 20'(i), 1'b0, 8'd2, 1'b1, pf(i), 1'(i));

    fill(20'h105, 8'd1, 20'hAAAAA, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++)
      look("R6 rewrite", 20'h100 + 20'(i), 1'b1, 8'd1, 1'b1, (i == 5) ? 20'hAAAAA : pf(i), (i == 5) ? 1'b0 : 1'(i));

    fill(20'h200, 8'd1, 20'h11, 1'b0, 1'b0);
    look("R7 new0", 20'h200, 1'b1, 8'd1, 1'b1, 20'h11, 1'b0);
    for (int i = 0; i < 16; i++)
      if (i != 5) look("R7 evict0", 20'h100 + 20'(i), 1'b1, 8'd1, i != 0, pf(i), 1'(i));
    fill(20'h201, 8'd1, 20'h12, 1'b1, 1'b0);
    look("R7 new1", 20'h201, 1'b1, 8'd1, 1'b1, 20'h12, 1'b1);
    look("R7 evict1", 20'h101, 1'b1, 8'd1, 1'b0, '0, 1'b0);
    look("R7 keep2", 20'h102, 1'b1, 8'd1, 1'b1, pf(2), 1'b0);

    fill(20'h102, 8'd1, pf(2), 1'b0, 1'b1);
    fill(20'h202, 8'd1, 20'h13, 1'b0, 1'b0);
    look("R8 wired kept", 20'h102, 1'b1, 8'd1, 1'b1, pf(2), 1'b0);
    look("R8 skip to 3", 20'h103, 1'b1, 8'd1, 1'b0, '0, 1'b0);
    look("R8 new", 20'h202, 1'b1, 8'd1, 1'b1, 20'h13, 1'b0);
    look("R8 keep4", 20'h104, 1'b1, 8'd1, 1'b1, pf(4), 1'b0);

    do_flush(1'b1, 8'd7);
    look("R9 other asid kept", 20'h104, 1'b1, 8'd1, 1'b1, pf(4), 1'b0);
    look("R9 other asid kept", 20'h200, 1'b1, 8'd1, 1'b1, 20'h11, 1'b0);
    do_flush(1'b1, 8'd1);
    for (int i = 4; i < 16; i++) look("R9 cleared", 20'h100 + 20'(i), 1'b1, 8'd1, 1'b0, '0, 1'b0);
    look("R9 cleared", 20'h200, 1'b1, 8'd1, 1'b0, '0, 1'b0);
    look("R9 wired kept", 20'h102, 1'b1, 8'd1, 1'b1, pf(2), 1'b0);

    fill(20'h300, 8'd9, 20'h33, 1'b1, 1'b0);
    look("R5 asid9", 20'h300, 1'b1, 8'd9, 1'b1, 20'h33, 1'b1);
    do_flush(1'b0, 8'd1);
    look("R10 cleared", 20'h300, 1'b1, 8'd9, 1'b0, '0, 1'b0);
    look("R10 wired kept", 20'h102, 1'b0, 8'd1, 1'b1, pf(2), 1'b0);

    for (int i = 0; i < 15; i++) fill(20'h400 + 20'(i), 8'd1, pf(i + 40), 1'b1, 1'b1);
    check("R11 last free fill", 32'(last_drop), 0);
    fill(20'h500, 8'd1, 20'h55, 1'b0, 1'b0);
    check("R11 drop pulse", 32'(last_drop), 1);
    @(negedge clk);
    #1 check("R11 drop falls", 32'(fill_drop), 0);
    look("R11 not installed", 20'h500, 1'b1, 8'd1, 1'b0, '0, 1'b0);
    for (int i = 0; i < 15; i++) look("R11 table intact", 20'h400 + 20'(i), 1'b1, 8'd1, 1'b1, pf(i + 40), 1'b1);
    look("R11 table intact", 20'h102, 1'b1, 8'd1, 1'b1, pf(2), 1'b0);
    do_flush(1'b0, 8'd0);
    look("R10 all wired kept", 20'h40E, 1'b1, 8'd1, 1'b1, pf(54), 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule